// File: doc/BRIEF.md
# CAN Controller Control and Interrupt Register Bank

This block is the host-facing register front end of a CAN controller. A host reaches it through a plain 32-bit register bus with separate write and read strobes. It holds five registers: a mode register that drives the controller's operating levels, a command register that turns written bits into single-cycle strobes, a status register that captures level signals from the protocol core, an interrupt enable register, and an interrupt flag register whose bits the host clears by writing ones. One interrupt line to the host is high while any flag is set.

The protocol engine, the message buffers and the acceptance filters sit outside this block. They appear only as an 8-bit status level input and an 8-bit event pulse input. A write takes effect at the clock edge where `bus_wr_en` is sampled high. A read is sampled at its edge and returns its data one cycle later, marked by `bus_rd_valid`. The bus has no back-pressure: every access completes in one cycle, and a read and a write may be issued in the same cycle. Register offsets are 0x00 mode, 0x04 command, 0x08 status, 0x0C interrupt flags and 0x10 interrupt enable. Address bits 1:0 are ignored.

Top module: `can_ctrl_regs`

## Requirements
- R1: After reset the mode register reads 0x01, and `mode_reset` is 1 while the other four mode outputs are 0. Mode bits: 0 reset, 1 listen-only, 2 loopback, 3 single filter (0 means dual filters), 4 sleep.
- R2: Mode bits 3 and 4 take a written value only when mode bit 0 is 1 before the write. Otherwise the write leaves them unchanged, both on readback and on their outputs.
- R3: Mode bits 0, 1 and 2 take the written value on every mode write. Register bits above bit 4 read as zero whatever is written.
- R4: A write to the command register drives, in the cycle after the write edge, a one-cycle pulse on each strobe whose bit was 1 (bit 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off). The strobes are 0 in the following cycle, and a read of the command register returns 0.
- R5: The status register resets to 0x3C. After that it holds the value of `core_status` sampled at the previous clock edge. Reads return that value in bits 7:0.
- R6: An interrupt flag bit is set by a `core_evt` pulse on the same bit only if that bit of the enable register is 1. Flag and enable bits: 0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R8: When an enabled event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly while at least one interrupt flag is set.
- R10: The interrupt enable register resets to 0 and reads back its written 8 bits, with bits above bit 7 reading as zero.
- R11: Read data appears with `bus_rd_valid` one cycle after `bus_rd_en`, and shows register contents from before any write in the same cycle. An unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | High for one cycle after each read |
| core_status | input | 8 | Status levels from the protocol core |
| core_evt | input | 8 | Event pulses from the protocol core |
| mode_reset | output | 1 | Controller held in reset mode |
| mode_listen_only | output | 1 | Listen-only operation |
| mode_loopback | output | 1 | Internal loopback operation |
| mode_single_filter | output | 1 | Single acceptance filter selected |
| mode_sleep | output | 1 | Sleep requested |
| cmd_tx_req | output | 1 | Transmit request strobe |
| cmd_abort | output | 1 | Abort strobe |
| cmd_rx_release | output | 1 | Release receive buffer strobe |
| cmd_clr_overrun | output | 1 | Clear overrun strobe |
| cmd_self_rx | output | 1 | Self-receive request strobe |
| cmd_bus_off | output | 1 | Bus-off request strobe |
| irq | output | 1 | Interrupt request to the host |

## Verification
A wrong mode state shows at once on the five mode outputs, one cycle after the write that caused it, and on the next mode read. A stuck or wrongly set interrupt flag shows on `irq` in the same cycle the flag changes. It also shows on the next flag read, which exposes the exact bit. Command strobes have no stored state, so an error there shows as a pulse that is missing, misplaced or lasts more than one cycle, within two cycles of the write.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
  localparam int MODE_W = 5;
  localparam int CMD_W  = 6;
  localparam int EVT_W  = 8;
  localparam int STAT_W = 8;

  // byte offsets seen by software
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_FLAG = 8'h0C;
  localparam logic [7:0] OFS_EN   = 8'h10;

  // mode bit positions
  localparam int MB_RST    = 0;
  localparam int MB_LISTEN = 1;
  localparam int MB_LOOP   = 2;
  localparam int MB_SINGLE = 3;
  localparam int MB_SLEEP  = 4;

  // command bit positions
  localparam int CB_TX      = 0;
  localparam int CB_ABORT   = 1;
  localparam int CB_RELEASE = 2;
  localparam int CB_CLR_OVR = 3;
  localparam int CB_SELF_RX = 4;
  localparam int CB_BUSOFF  = 5;

  localparam logic [MODE_W-1:0] MODE_RST_VAL     = 5'h01;
  localparam logic [MODE_W-1:0] MODE_LOCKED_MASK = 5'b11000;
  localparam logic [STAT_W-1:0] STAT_RST_VAL     = 8'h3C;
endpackage

// File: rtl/can_mode_reg.sv
module can_mode_reg
  import can_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q
);
  logic              cfg_open;
  logic [MODE_W-1:0] mode_d;

  // sleep and filter select only move while the controller sits in reset mode
  assign cfg_open = mode_q[MB_RST];

  always_comb begin
    if (cfg_open) mode_d = wr_data;
    else          mode_d = (wr_data & ~MODE_LOCKED_MASK) | (mode_q & MODE_LOCKED_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= MODE_RST_VAL;
    else if (wr_en) mode_q <= mode_d;
  end

  // R2: locked bits hold while reset mode is off
  a_r2_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[MB_RST] |=> ($stable(mode_q[MB_SLEEP]) && $stable(mode_q[MB_SINGLE])));

  // R3: the register only moves on a write
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/can_cmd_strobe.sv
module can_cmd_strobe
  import can_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  output logic [CMD_W-1:0] pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pulse_q <= '0;
    else if (wr_en) pulse_q <= wr_data;
    else            pulse_q <= '0;
  end

  // R4: a strobe only follows a command write
  a_r4_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |-> $past(wr_en));
endmodule

// File: rtl/can_status_capture.sv
module can_status_capture
  import can_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] core_status,
  output logic [STAT_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= STAT_RST_VAL;
    else        status_q <= core_status;
  end

  // R5: one register stage behind the core levels
  a_r5_tracks_core: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_q == $past(core_status)));
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         en_wr,
  input  logic         flag_wr,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] en_q,
  output logic [N-1:0] flag_q,
  output logic         irq
);
  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign set_v[i]  = evt[i] & en_q[i];
    assign clr_v[i]  = flag_wr & wr_data[i];
    // a fresh event beats a clear landing in the same cycle
    assign flag_d[i] = set_v[i] | (flag_q[i] & ~clr_v[i]);

    // R6: a flag rises only from an enabled event
    a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(evt[i] && en_q[i]));

    // R8: enabled event always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && en_q[i]) |=> flag_q[i]);

    // R7: a clear without a competing event drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wr_data[i] && !(evt[i] && en_q[i])) |=> !flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr) en_q <= wr_data;
      flag_q <= flag_d;
    end
  end

  assign irq = |flag_q;
endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
  import can_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd_valid,
  input  logic [STAT_W-1:0] core_status,
  input  logic [EVT_W-1:0]  core_evt,
  output logic              mode_reset,
  output logic              mode_listen_only,
  output logic              mode_loopback,
  output logic              mode_single_filter,
  output logic              mode_sleep,
  output logic              cmd_tx_req,
  output logic              cmd_abort,
  output logic              cmd_rx_release,
  output logic              cmd_clr_overrun,
  output logic              cmd_self_rx,
  output logic              cmd_bus_off,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  function automatic logic word_hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    logic [ADDR_W-1:0] o;
    o = ADDR_W'(ofs);
    return a[ADDR_W-1:2] == o[ADDR_W-1:2];
  endfunction

  logic hit_mode, hit_cmd, hit_stat, hit_flag, hit_en;
  assign hit_mode = word_hit(bus_addr, OFS_MODE);
  assign hit_cmd  = word_hit(bus_addr, OFS_CMD);
  assign hit_stat = word_hit(bus_addr, OFS_STAT);
  assign hit_flag = word_hit(bus_addr, OFS_FLAG);
  assign hit_en   = word_hit(bus_addr, OFS_EN);

  logic [WORD_W-1:0] unused_word;
  logic              unused_bits;
  assign unused_word = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:EVT_W], unused_word};

  logic [MODE_W-1:0] mode_q;
  logic [CMD_W-1:0]  pulse_q;
  logic [STAT_W-1:0] status_q;
  logic [EVT_W-1:0]  en_q;
  logic [EVT_W-1:0]  flag_q;

  can_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en && hit_mode),
    .wr_data (bus_wdata[MODE_W-1:0]),
    .mode_q  (mode_q)
  );

  can_cmd_strobe u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en && hit_cmd),
    .wr_data (bus_wdata[CMD_W-1:0]),
    .pulse_q (pulse_q)
  );

  can_status_capture u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_status (core_status),
    .status_q    (status_q)
  );

  can_irq_ctrl #(.N(EVT_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (core_evt),
    .en_wr   (bus_wr_en && hit_en),
    .flag_wr (bus_wr_en && hit_flag),
    .wr_data (bus_wdata[EVT_W-1:0]),
    .en_q    (en_q),
    .flag_q  (flag_q),
    .irq     (irq)
  );

  // read mux: command word and unmapped words return zero
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (hit_mode)      rd_next[MODE_W-1:0] = mode_q;
    else if (hit_stat) rd_next[STAT_W-1:0] = status_q;
    else if (hit_flag) rd_next[EVT_W-1:0]  = flag_q;
    else if (hit_en)   rd_next[EVT_W-1:0]  = en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_rd_valid <= 1'b0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_next;
    end
  end

  assign mode_reset         = mode_q[MB_RST];
  assign mode_listen_only   = mode_q[MB_LISTEN];
  assign mode_loopback      = mode_q[MB_LOOP];
  assign mode_single_filter = mode_q[MB_SINGLE];
  assign mode_sleep         = mode_q[MB_SLEEP];

  assign cmd_tx_req      = pulse_q[CB_TX];
  assign cmd_abort       = pulse_q[CB_ABORT];
  assign cmd_rx_release  = pulse_q[CB_RELEASE];
  assign cmd_clr_overrun = pulse_q[CB_CLR_OVR];
  assign cmd_self_rx     = pulse_q[CB_SELF_RX];
  assign cmd_bus_off     = pulse_q[CB_BUSOFF];

  // R11: every read is answered in the next cycle
  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid);

  // R4: the command word never reads back
  a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && hit_cmd) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_can_ctrl_regs.sv
`timescale 1ns/1ps
module tb_can_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rd_valid;
  logic [7:0]  core_status = 8'h00;
  logic [7:0]  core_evt = 8'h00;
  logic mode_reset, mode_listen_only, mode_loopback, mode_single_filter, mode_sleep;
  logic cmd_tx_req, cmd_abort, cmd_rx_release, cmd_clr_overrun, cmd_self_rx, cmd_bus_off;
  logic irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  can_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd_valid(bus_rd_valid), .core_status(core_status), .core_evt(core_evt),
    .mode_reset(mode_reset), .mode_listen_only(mode_listen_only),
    .mode_loopback(mode_loopback), .mode_single_filter(mode_single_filter),
    .mode_sleep(mode_sleep), .cmd_tx_req(cmd_tx_req), .cmd_abort(cmd_abort),
    .cmd_rx_release(cmd_rx_release), .cmd_clr_overrun(cmd_clr_overrun),
    .cmd_self_rx(cmd_self_rx), .cmd_bus_off(cmd_bus_off), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected read data", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk);
    core_evt = v;
    @(negedge clk);
    core_evt = 8'h00;
  endtask

  function automatic logic [31:0] mode_pins();
    return {27'd0, mode_sleep, mode_single_filter, mode_loopback, mode_listen_only, mode_reset};
  endfunction

  function automatic logic [31:0] cmd_pins();
    return {26'd0, cmd_bus_off, cmd_self_rx, cmd_clr_overrun, cmd_rx_release, cmd_abort, cmd_tx_req};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: first read after reset sees the reset value, not the input
    rst_n = 1'b1; bus_rd_en = 1'b1; bus_addr = 8'h08;
    exp_q.push_back(32'h3C); tag_q.push_back("R5 status reset value");
    @(negedge clk);
    bus_rd_en = 1'b0;
    check("R1 mode pins after reset", mode_pins(), 32'h01);
    check("R9 irq low after reset", {31'd0, irq}, 32'h0);
    check("R4 strobes idle after reset", cmd_pins(), 32'h0);
    rd(8'h00, 32'h01, "R1 mode reset value");
    rd(8'h10, 32'h00, "R10 enable reset value");
    rd(8'h08, 32'h00, "R5 status follows input");
    rd(8'h14, 32'h0, "R11 unmapped 0x14");
    rd(8'h1C, 32'h0, "R11 unmapped 0x1C");

    // R2: locked bits writable in reset mode
    wr(8'h00, 32'h19);
    check("R2 pins after write in reset mode", mode_pins(), 32'h19);
    rd(8'h00, 32'h19, "R2 readback in reset mode");
    // R3: leave reset mode, set listen and loopback
    wr(8'h00, 32'h06);
    check("R3 pins leave reset", mode_pins(), 32'h06);
    // R2: sleep/filter writes ignored outside reset mode
    wr(8'h00, 32'h1E);
    check("R2 sleep ignored outside reset", mode_pins(), 32'h06);
    rd(8'h00, 32'h06, "R2 readback outside reset");
    wr(8'h00, 32'hFFFF_FFE1);
    rd(8'h00, 32'h01, "R3 unused bits and re-enter reset");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h1F, "R3 all bits in reset mode");

    // R4: command strobes
    wr(8'h04, 32'h21);
    check("R4 strobe tx and bus-off", cmd_pins(), 32'h21);
    @(negedge clk);
    check("R4 strobe one cycle", cmd_pins(), 32'h0);
    wr(8'h04, 32'h3F);
    check("R4 all strobes", cmd_pins(), 32'h3F);
    @(negedge clk);
    check("R4 all strobes cleared", cmd_pins(), 32'h0);
    wr(8'h04, 32'h0C);
    check("R4 release and clear overrun", cmd_pins(), 32'h0C);
    rd(8'h04, 32'h0, "R4 command reads zero");

    // R5: status capture
    core_status = 8'hA5;
    rd(8'h08, 32'hA5, "R5 status A5");
    core_status = 8'h5A;
    rd(8'h08, 32'h5A, "R5 status 5A");

    // R6: events ignored while disabled
    pulse_evt(8'hFF);
    check("R6 no irq while disabled", {31'd0, irq}, 32'h0);
    rd(8'h0C, 32'h0, "R6 flags stay clear while disabled");
    wr(8'h10, 32'h0F);
    rd(8'h10, 32'h0F, "R10 enable readback");
    pulse_evt(8'hF0);
    rd(8'h0C, 32'h0, "R6 disabled upper events ignored");
    pulse_evt(8'h05);
    check("R9 irq with flags", {31'd0, irq}, 32'h1);
    rd(8'h0C, 32'h05, "R6 enabled events set flags");

    // R7: write-one-to-clear
    wr(8'h0C, 32'h04);
    rd(8'h0C, 32'h01, "R7 clear bit 2");
    wr(8'h0C, 32'h00);
    rd(8'h0C, 32'h01, "R7 zero write keeps flag");
    check("R9 irq still high", {31'd0, irq}, 32'h1);
    wr(8'h0C, 32'h01);
    check("R9 irq drops when clear", {31'd0, irq}, 32'h0);
    rd(8'h0C, 32'h00, "R7 last flag cleared");

    // R8: event and clear in the same cycle
    @(negedge clk);
    core_evt = 8'h02; bus_wr_en = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h02;
    @(negedge clk);
    core_evt = 8'h00; bus_wr_en = 1'b0;
    check("R8 set wins irq", {31'd0, irq}, 32'h1);
    rd(8'h0C, 32'h02, "R8 set wins over clear");
    wr(8'h0C, 32'hFF);
    check("R9 irq low after clear all", {31'd0, irq}, 32'h0);

    // R10: full enable width
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'hFF, "R10 unused enable bits zero");
    pulse_evt(8'h80);
    rd(8'h0C, 32'h80, "R6 bus error flag");

    // R11: read and write in the same cycle return the old value
    @(negedge clk);
    bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h33;
    exp_q.push_back(32'hFF); tag_q.push_back("R11 read before same-cycle write");
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    rd(8'h10, 32'h33, "R11 write visible afterwards");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule